// File: doc/BRIEF.md
# Isochronous IN Double-Buffered Transmit Store

This block holds outgoing data for one isochronous IN endpoint in two equal byte banks that trade roles at every start of frame. The local processor selects the endpoint, pushes the bytes for the coming frame into the bank it currently owns (the write bank), and then drops the select. The USB-side engine sees only the other bank (the send bank). When it reports an IN token, the block streams every byte of the send bank, one byte per clock, and marks the final byte.

Isochronous traffic has no acknowledgement and no retry. A packet leaves once, and the send bank is empty afterwards, so a frame carries at most one data packet. Token decoding, CRC, bit-level serialization and start-of-frame detection happen elsewhere. They reach this block as single-cycle strobes.

Top module: `iso_in_pingpong_tx`

## Requirements
- R1: After a synchronous reset, `tx_valid_o`, `tx_last_o` and `ovf_o` are 0, and `fg_level_o` is 0.
- R2: A byte on `host_wdata_i` is stored only when `host_wr_i` and `host_sel_i` are both high. Each stored byte raises `fg_level_o` by one on the next cycle. A write while `host_sel_i` is low leaves `fg_level_o` unchanged.
- R3: The write bank holds `DEPTH` (64) bytes. A write to a full bank is dropped, and `fg_level_o` stays at 64. `ovf_o` goes high on the next cycle and stays high until the cycle after the next `sof_i`, which clears it.
- R4: `sof_i` with `host_sel_i` low swaps the banks. The filled write bank becomes the send bank. The old send bank becomes the write bank and is emptied, so `fg_level_o` reads 0 on the next cycle. Bytes written after the swap do not alter the pending send data.
- R5: `sof_i` with `host_sel_i` high does not swap. The send bank is discarded, so a token in that frame yields a zero-length packet. The write bank keeps its bytes and its level.
- R6: `in_tok_i` while idle, with N ≥ 1 bytes in the send bank, gives N consecutive cycles of `tx_valid_o`, starting on the cycle after the token. The bytes leave in write order, and `tx_last_o` is high only with the Nth byte.
- R7: `in_tok_i` while idle, with an empty send bank, gives a zero-length packet: one cycle of `tx_last_o` high with `tx_valid_o` low, on the cycle after the token.
- R8: A packet empties the send bank. A second token in the same frame produces a zero-length packet.
- R9: `in_tok_i` arriving while a packet is streaming is ignored. The packet is not cut short, and no packet follows it.
- R10: When `in_tok_i` and `sof_i` fall in the same cycle, the token is served from the send bank as it stands after that start of frame.
- R11: A write and `sof_i` in the same cycle, with `host_sel_i` high, keeps the write: `fg_level_o` reads the previous level plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_i | input | 1 | Endpoint select from the local processor; low means the write bank is complete |
| host_wr_i | input | 1 | Byte write strobe |
| host_wdata_i | input | 8 | Byte to store |
| sof_i | input | 1 | Start-of-frame strobe |
| in_tok_i | input | 1 | IN token strobe for this endpoint |
| tx_valid_o | output | 1 | Outgoing byte is valid |
| tx_data_o | output | 8 | Outgoing byte |
| tx_last_o | output | 1 | Final byte of the packet, or a zero-length packet when `tx_valid_o` is low |
| fg_level_o | output | 7 | Number of bytes in the write bank |
| ovf_o | output | 1 | Sticky write-overflow flag for the current frame |

## Verification
Two events can land on the same clock edge: the start of frame that swaps the banks, and the IN token that reads the send bank. The bench fills the write bank and releases the select. It then raises `sof_i` and `in_tok_i` together, and expects a packet carrying exactly the bytes that the swap just moved into the send bank, not the empty pre-swap bank. The bench also drives a write in the same cycle as a start of frame with the select still high, and checks the write-bank level afterwards.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

  // What a start of frame does to the two banks
  typedef enum logic [1:0] {
    FR_KEEP = 2'd0,  // no start of frame this cycle
    FR_SWAP = 2'd1,  // write bank complete: trade roles
    FR_DROP = 2'd2   // write bank incomplete: discard the send bank
  } frame_act_e;

  function automatic frame_act_e frame_action(input logic sof, input logic sel);
    if (!sof)     return FR_KEEP;
    else if (sel) return FR_DROP;
    else          return FR_SWAP;
  endfunction

endpackage

// File: rtl/iso_tx_bank_ram.sv
module iso_tx_bank_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  // Both banks share one array: the top address bit picks the bank
  logic [DATA_W-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/iso_tx_fill_ctrl.sv
module iso_tx_fill_ctrl
  import iso_tx_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              sel,
  input  logic              wr,
  input  logic              take,      // reader starts a packet this cycle
  output logic              wr_en,
  output logic [ADDR_W:0]   wr_addr,
  output logic              bg_bank,   // send bank after this cycle's frame action
  output logic [CNT_W-1:0]  bg_len,
  output logic [CNT_W-1:0]  level_q,
  output logic              ovf_q
);

  logic              fg_q, fg_nx;
  logic [CNT_W-1:0]  cnt_q [2];
  logic [CNT_W-1:0]  cnt_nx [2];
  logic              ovf_nx;
  logic              full;
  frame_act_e        act;

  assign act  = frame_action(sof, sel);
  assign full = (cnt_q[fg_q] == CNT_W'(DEPTH));

  // Writes need the select high, so they never coincide with a swap
  assign wr_en   = sel && wr && !full;
  assign wr_addr = {fg_q, cnt_q[fg_q][ADDR_W-1:0]};

  always_comb begin
    fg_nx     = fg_q;
    cnt_nx[0] = cnt_q[0];
    cnt_nx[1] = cnt_q[1];
    ovf_nx    = ovf_q;

    unique case (act)
      FR_SWAP: begin
        fg_nx          = ~fg_q;
        cnt_nx[~fg_q]  = '0;          // old send bank becomes an empty write bank
        ovf_nx         = 1'b0;
      end
      FR_DROP: begin
        cnt_nx[~fg_q]  = '0;          // incomplete frame: nothing to send
        ovf_nx         = 1'b0;
      end
      default: ;
    endcase

    if (wr_en)
      cnt_nx[fg_q] = cnt_q[fg_q] + CNT_W'(1);
    if (sel && wr && full)
      ovf_nx = 1'b1;

    bg_bank = ~fg_nx;
    bg_len  = cnt_nx[~fg_nx];
    if (take)
      cnt_nx[~fg_nx] = '0;            // one packet per frame
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q     <= 1'b0;
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      ovf_q    <= 1'b0;
      level_q  <= '0;
    end else begin
      fg_q     <= fg_nx;
      cnt_q[0] <= cnt_nx[0];
      cnt_q[1] <= cnt_nx[1];
      ovf_q    <= ovf_nx;
      level_q  <= cnt_nx[fg_nx];
    end
  end

endmodule

// File: rtl/iso_tx_reader.sv
module iso_tx_reader #(
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok,
  input  logic              bg_bank,
  input  logic [CNT_W-1:0]  bg_len,
  output logic              take,
  output logic              rd_en,
  output logic [ADDR_W:0]   rd_addr,
  output logic              valid_q,
  output logic              last_q
);

  logic              active_q;
  logic              bank_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  len_q;
  logic              at_end;

  assign take   = tok && !active_q;
  assign at_end = (idx_q == len_q - CNT_W'(1));

  // First byte is addressed in the token cycle so it leaves one cycle later
  assign rd_en   = active_q || (take && bg_len != '0);
  assign rd_addr = active_q ? {bank_q, idx_q[ADDR_W-1:0]} : {bg_bank, {ADDR_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      bank_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      if (active_q) begin
        valid_q <= 1'b1;
        last_q  <= at_end;
        idx_q   <= idx_q + CNT_W'(1);
        if (at_end) active_q <= 1'b0;
      end else if (take) begin
        bank_q <= bg_bank;
        len_q  <= bg_len;
        idx_q  <= CNT_W'(1);
        if (bg_len == '0) begin
          last_q <= 1'b1;             // zero-length packet
        end else begin
          valid_q  <= 1'b1;
          last_q   <= (bg_len == CNT_W'(1));
          active_q <= (bg_len != CNT_W'(1));
        end
      end
    end
  end

endmodule

// File: rtl/iso_in_pingpong_tx.sv
module iso_in_pingpong_tx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              sof_i,
  input  logic              in_tok_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_last_o,
  output logic [CNT_W-1:0]  fg_level_o,
  output logic              ovf_o
);

  logic              wr_en;
  logic [ADDR_W:0]   wr_addr;
  logic              rd_en;
  logic [ADDR_W:0]   rd_addr;
  logic              take;
  logic              bg_bank;
  logic [CNT_W-1:0]  bg_len;

  iso_tx_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .sof     (sof_i),
    .sel     (host_sel_i),
    .wr      (host_wr_i),
    .take    (take),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .bg_bank (bg_bank),
    .bg_len  (bg_len),
    .level_q (fg_level_o),
    .ovf_q   (ovf_o)
  );

  iso_tx_reader #(.DEPTH(DEPTH)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .tok     (in_tok_i),
    .bg_bank (bg_bank),
    .bg_len  (bg_len),
    .take    (take),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .valid_q (tx_valid_o),
    .last_q  (tx_last_o)
  );

  iso_tx_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (host_wdata_i),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (tx_data_o)
  );

endmodule

// File: rtl/iso_in_pingpong_tx_chk.sv
module iso_in_pingpong_tx_chk #(
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             host_sel_i,
  input logic             host_wr_i,
  input logic             sof_i,
  input logic             in_tok_i,
  input logic             tx_valid_o,
  input logic             tx_last_o,
  input logic [CNT_W-1:0] fg_level_o,
  input logic             ovf_o
);

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    fg_level_o <= CNT_W'(DEPTH)); // R3

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    host_sel_i && host_wr_i && fg_level_o == CNT_W'(DEPTH)
    |=> fg_level_o == CNT_W'(DEPTH) && ovf_o); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_o && !sof_i |=> ovf_o); // R3

  AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !host_sel_i && !sof_i |=> $stable(fg_level_o)); // R2

  AST_SWAP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    sof_i && !host_sel_i |=> fg_level_o == '0); // R4

  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_last_o |=> tx_valid_o); // R6

  AST_TOKEN_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    in_tok_i && !(tx_valid_o && !tx_last_o) |=> tx_valid_o || tx_last_o); // R7

endmodule

bind iso_in_pingpong_tx iso_in_pingpong_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_sel_i (host_sel_i),
  .host_wr_i  (host_wr_i),
  .sof_i      (sof_i),
  .in_tok_i   (in_tok_i),
  .tx_valid_o (tx_valid_o),
  .tx_last_o  (tx_last_o),
  .fg_level_o (fg_level_o),
  .ovf_o      (ovf_o)
);

// File: tb/iso_in_pingpong_tx_tb.sv
module iso_in_pingpong_tx_tb;

  localparam int DEPTH = 64;
  localparam int NVEC  = 7;
  // Each entry: {byte count, pattern seed}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h01_10, 16'h02_A0, 16'h05_33, 16'h11_5C, 16'h3F_01, 16'h40_C7, 16'h00_00
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sel_i = 1'b0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic       sof_i = 1'b0;
  logic       in_tok_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_last_o;
  logic [6:0] fg_level_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  iso_in_pingpong_tx #(.DATA_W(8), .DEPTH(DEPTH)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .host_sel_i   (host_sel_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .sof_i        (sof_i),
    .in_tok_i     (in_tok_i),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .tx_last_o    (tx_last_o),
    .fg_level_o   (fg_level_o),
    .ovf_o        (ovf_o)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Leaves the select high
  task automatic fill(input int n, input logic [7:0] seed);
    host_sel_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      host_wr_i = 1'b1;
      host_wdata_i = pat(seed, i);
      tick();
    end
    host_wr_i = 1'b0;
  endtask

  task automatic frame(input bit sel);
    host_sel_i = sel;
    sof_i = 1'b1;
    tick();
    sof_i = 1'b0;
  endtask

  // Token pulse, then gather the packet; poke_at re-raises the token mid-stream
  task automatic packet(input int exp_n, input logic [7:0] seed, input string req,
                        input int poke_at);
    int n = 0;
    int bad = 0;
    in_tok_i = 1'b1;
    tick();
    in_tok_i = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (tx_valid_o) begin
        if (tx_data_o != pat(seed, n)) bad++;
        n++;
      end
      if (tx_last_o) break;
      in_tok_i = (k == poke_at);
      tick();
      in_tok_i = 1'b0;
    end
    chk(n == exp_n, {req, " length"}, n, exp_n);
    chk(bad == 0, {req, " data"}, bad, 0);
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    chk(!tx_valid_o && !tx_last_o && !ovf_o, "R1 outputs", {tx_valid_o, tx_last_o, ovf_o}, 0);
    chk(fg_level_o == 0, "R1 level", fg_level_o, 0);

    // R2: writes without select are ignored
    host_sel_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      host_wr_i = 1'b1; host_wdata_i = 8'hEE; tick();
    end
    host_wr_i = 1'b0;
    tick();
    chk(fg_level_o == 0, "R2 unselected write", fg_level_o, 0);

    // Vector table: fill, complete, swap, send
    for (int v = 0; v < NVEC; v++) begin
      int n = int'(VEC[v][15:8]);
      fill(n, VEC[v][7:0]);
      chk(fg_level_o == 7'(n), "R2 level after fill", fg_level_o, n);
      frame(1'b0);
      chk(fg_level_o == 0, "R4 level after swap", fg_level_o, 0);
      packet(n, VEC[v][7:0], (n == 0) ? "R7 zero-length" : "R6 packet", -1);
    end

    // R8: second token in the same frame
    fill(3, 8'h21);
    frame(1'b0);
    packet(3, 8'h21, "R6 packet", -1);
    packet(0, 8'h00, "R8 repeat token", -1);

    // R3: overflow
    fill(DEPTH, 8'h44);
    chk(fg_level_o == 7'(DEPTH) && !ovf_o, "R3 full no flag", {ovf_o, fg_level_o}, DEPTH);
    fill(1, 8'hFF);
    chk(fg_level_o == 7'(DEPTH), "R3 level held", fg_level_o, DEPTH);
    chk(ovf_o, "R3 flag set", ovf_o, 1);
    tick();
    chk(ovf_o, "R3 flag sticky", ovf_o, 1);
    frame(1'b0);
    chk(!ovf_o, "R3 flag cleared by frame", ovf_o, 0);
    packet(DEPTH, 8'h44, "R3 dropped byte absent", -1);

    // R5: frame with select still high
    fill(3, 8'h90);
    frame(1'b0);
    fill(2, 8'h61);
    frame(1'b1);
    chk(fg_level_o == 2, "R5 write bank kept", fg_level_o, 2);
    packet(0, 8'h00, "R5 send bank dropped", -1);
    frame(1'b0);
    packet(2, 8'h61, "R5 kept bytes sent later", -1);

    // R4: writes after a swap leave pending send data intact
    fill(5, 8'h12);
    frame(1'b0);
    fill(7, 8'hB0);
    host_sel_i = 1'b0;
    packet(5, 8'h12, "R4 pending data intact", -1);
    frame(1'b0);
    packet(7, 8'hB0, "R4 new frame data", -1);

    // R9: token during streaming
    fill(10, 8'h3C);
    frame(1'b0);
    packet(10, 8'h3C, "R9 stream not disturbed", 3);
    begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        if (tx_valid_o || tx_last_o) extra++;
        tick();
      end
      chk(extra == 0, "R9 no extra packet", extra, 0);
    end

    // R10: token and frame in the same cycle
    fill(4, 8'h77);
    host_sel_i = 1'b0;
    sof_i = 1'b1;
    packet(4, 8'h77, "R10 token with frame", -1);
    sof_i = 1'b0;

    // R11: write and frame in the same cycle, select high
    fill(3, 8'h05);
    host_wr_i = 1'b1;
    host_wdata_i = 8'h55;
    frame(1'b1);
    host_wr_i = 1'b0;
    chk(fg_level_o == 4, "R11 write with frame", fg_level_o, 4);
    host_sel_i = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule